// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block decodes one 16-bit fixed-width instruction word. The major opcode sits in the low nibble. The position of each other field depends on the format. The decoder returns the register indices, the ALU function code and a 16-bit sign-extended immediate. It also returns the control set that an execute stage needs: register write enable, destination index, operand-B source, memory read and write, branch kind, link write and an illegal-instruction flag.

The caller presents a word on `insn_i` and raises `valid_i`. After the next rising clock edge, all outputs hold the decode of that word. When `valid_i` is low at the edge, every output goes to zero, so the execute stage sees a bubble. The register file, the ALU, memory and the extended system instructions belong to other blocks. Extended encodings are flagged as illegal and have no other effect.

Top module: `insn_decoder`

## Requirements
- R1: Outputs are registered. A word accepted with `valid_i` high appears after the next rising edge together with `vld_o`=1. After an edge at which `valid_i` is low, every output is zero. Reset also clears every output. Any field that the decoded format does not use reads zero.
- R2: `ra_o` is bits [7:4] for opcodes 0000 through 1011. It is zero for 1100, 1101, 1110 and 1111.
- R3: Opcode 0000 gives fn 0000 (move) and opcode 0001 gives fn 0111 (high-byte merge). Both take their immediate from bits [15:8], sign-extended, and set `opb_imm_o`=1, `rd_o`=Ra and `rf_we_o`=1.
- R4: Opcode 0010 gives fn=[15:12], rb=[11:8] and rd=Ra, with a register operand B. Opcode 0011 gives fn=[11:8] and an immediate from bits [15:12], sign-extended, with `opb_imm_o`=1 and rd=Ra. Both set the write enable.
- R5: Opcodes 01cc give fn=[15:12] and rb=[11:8], with write enable set. The destination is the 2-bit field cc in bits [1:0], so only registers 0 to 3 can be selected.
- R6: Opcode 1000 (load) sets `mem_rd_o`, `rf_we_o` and rd=Ra. Opcode 1001 (store) sets `mem_wr_o` and no register write. Both give rb=[11:8], an immediate from bits [15:12] sign-extended, fn 0100 (add) and `opb_imm_o`=1.
- R7: Opcode 1010 gives `br_kind_o`=1 (taken if Ra nonzero). Opcode 1011 gives `br_kind_o`=2 (taken if Ra zero). Both take a sign-extended offset from bits [15:8].
- R8: Opcodes 1100 and 1101 give `br_kind_o`=3 (relative) with a sign-extended offset from bits [15:4]. Opcode 1101 also sets `link_o`=1, `rf_we_o`=1 and `rd_o`=14.
- R9: Under opcode 1110, sub-opcode [15:12]=0000 gives `br_kind_o`=4 (to register) with rb=[11:8]. Sub-opcode 0001 does the same and adds the link write to register 14. Sub-opcode 0010 is a no-op: every output is zero except `vld_o`.
- R10: Sub-opcodes 0011 to 1111 under 1110, and every word with opcode 1111, set `illegal_o`=1. For these words every field and every write, memory and branch control is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 16 | Instruction word |
| vld_o | output | 1 | Registered decode is valid |
| ra_o | output | 4 | Register index A |
| rb_o | output | 4 | Register index B |
| rd_o | output | 4 | Destination register index |
| fn_o | output | 4 | ALU function code |
| imm_o | output | 16 | Sign-extended immediate or offset |
| rf_we_o | output | 1 | Register file write enable |
| opb_imm_o | output | 1 | ALU operand B comes from the immediate |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| br_kind_o | output | 3 | 0 none, 1 if-nonzero, 2 if-zero, 3 relative, 4 to register |
| link_o | output | 1 | Write return address to register 14 |
| illegal_o | output | 1 | Unimplemented or undefined encoding |

## Verification
The bench applies all 65536 words and compares each result with a model written from the requirements. This sweep reaches the cases that are easy to get wrong:
- Swapped fn and immediate nibbles in opcode 0011 would put the wrong function on a fully varied bit pattern.
- Sign extension from the wrong bit would show up at the boundary offsets 7/-8, 127/-128 and 2047/-2048.
- A 01cc destination decoded as Ra would fail for every word whose Ra differs from cc.
- Extended encodings that still drive a branch or a write would disagree with the all-zero expectation.

Bubbles between words check that the decoder clears its outputs and does not hold the last decode.

// File: rtl/insn_pkg.sv
package insn_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned IDX_W  = 4;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_NZ   = 3'd1,
    BR_Z    = 3'd2,
    BR_REL  = 3'd3,
    BR_REG  = 3'd4
  } br_kind_e;

  localparam logic [IDX_W-1:0] FN_MOV   = 4'h0;
  localparam logic [IDX_W-1:0] FN_ADD   = 4'h4;
  localparam logic [IDX_W-1:0] FN_MHI   = 4'h7;
  localparam logic [IDX_W-1:0] LINK_IDX = 4'd14;

  typedef struct packed {
    logic [IDX_W-1:0]  ra;
    logic [IDX_W-1:0]  rb;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  fn;
    logic [WORD_W-1:0] imm;
    logic              rf_we;
    logic              opb_imm;
    logic              mem_rd;
    logic              mem_wr;
    br_kind_e          br;
    logic              link;
    logic              illegal;
  } dec_t;
endpackage

// File: rtl/insn_sext.sv
module insn_sext #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;
  assign ext_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/insn_dec_core.sv
module insn_dec_core
  import insn_pkg::*;
(
  input  logic [WORD_W-1:0] insn_i,
  output dec_t              dec_o
);
  localparam int unsigned IMM4_W  = 4;
  localparam int unsigned IMM8_W  = 8;
  localparam int unsigned IMM12_W = 12;

  logic [WORD_W-1:0] imm4, imm8, imm12;
  logic [3:0] op, hi, mid, ra_f;

  assign op   = insn_i[3:0];
  assign ra_f = insn_i[7:4];
  assign mid  = insn_i[11:8];
  assign hi   = insn_i[15:12];

  insn_sext #(.IN_W(IMM4_W),  .OUT_W(WORD_W)) u_sx4  (.val_i(insn_i[15:12]), .ext_o(imm4));
  insn_sext #(.IN_W(IMM8_W),  .OUT_W(WORD_W)) u_sx8  (.val_i(insn_i[15:8]),  .ext_o(imm8));
  insn_sext #(.IN_W(IMM12_W), .OUT_W(WORD_W)) u_sx12 (.val_i(insn_i[15:4]),  .ext_o(imm12));

  always_comb begin
    dec_o = '0;
    dec_o.br = BR_NONE;
    unique casez (op)
      4'b000?: begin
        dec_o.ra      = ra_f;
        dec_o.rd      = ra_f;
        dec_o.fn      = op[0] ? FN_MHI : FN_MOV;
        dec_o.imm     = imm8;
        dec_o.opb_imm = 1'b1;
        dec_o.rf_we   = 1'b1;
      end
      4'b0010: begin
        dec_o.ra    = ra_f;
        dec_o.rb    = mid;
        dec_o.rd    = ra_f;
        dec_o.fn    = hi;
        dec_o.rf_we = 1'b1;
      end
      4'b0011: begin
        dec_o.ra      = ra_f;
        dec_o.rd      = ra_f;
        dec_o.fn      = mid;
        dec_o.imm     = imm4;
        dec_o.opb_imm = 1'b1;
        dec_o.rf_we   = 1'b1;
      end
      4'b01??: begin
        dec_o.ra    = ra_f;
        dec_o.rb    = mid;
        dec_o.rd    = {2'b00, op[1:0]};
        dec_o.fn    = hi;
        dec_o.rf_we = 1'b1;
      end
      4'b100?: begin
        dec_o.ra      = ra_f;
        dec_o.rb      = mid;
        dec_o.fn      = FN_ADD;
        dec_o.imm     = imm4;
        dec_o.opb_imm = 1'b1;
        dec_o.mem_rd  = ~op[0];
        dec_o.mem_wr  = op[0];
        dec_o.rf_we   = ~op[0];
        dec_o.rd      = op[0] ? '0 : ra_f;
      end
      4'b101?: begin
        dec_o.ra  = ra_f;
        dec_o.imm = imm8;
        dec_o.br  = op[0] ? BR_Z : BR_NZ;
      end
      4'b110?: begin
        dec_o.imm   = imm12;
        dec_o.br    = BR_REL;
        dec_o.link  = op[0];
        dec_o.rf_we = op[0];
        dec_o.rd    = op[0] ? LINK_IDX : '0;
      end
      4'b1110: begin
        unique casez (hi)
          4'b000?: begin
            dec_o.rb    = mid;
            dec_o.br    = BR_REG;
            dec_o.link  = hi[0];
            dec_o.rf_we = hi[0];
            dec_o.rd    = hi[0] ? LINK_IDX : '0;
          end
          4'b0010: ;
          default: dec_o.illegal = 1'b1;
        endcase
      end
      default: dec_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_dec_reg.sv
module insn_dec_reg
  import insn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t dec_i,
  output logic vld_o,
  output dec_t dec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dec_o <= '0;
    end else begin
      vld_o <= valid_i;
      dec_o <= valid_i ? dec_i : '0;  // bubble clears all controls
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] insn_i,
  output logic              vld_o,
  output logic [IDX_W-1:0]  ra_o,
  output logic [IDX_W-1:0]  rb_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic [IDX_W-1:0]  fn_o,
  output logic [WORD_W-1:0] imm_o,
  output logic              rf_we_o,
  output logic              opb_imm_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [2:0]        br_kind_o,
  output logic              link_o,
  output logic              illegal_o
);
  dec_t dec_c, dec_q;

  insn_dec_core u_core (.insn_i(insn_i), .dec_o(dec_c));

  insn_dec_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .dec_i(dec_c), .vld_o(vld_o), .dec_o(dec_q)
  );

  assign ra_o      = dec_q.ra;
  assign rb_o      = dec_q.rb;
  assign rd_o      = dec_q.rd;
  assign fn_o      = dec_q.fn;
  assign imm_o     = dec_q.imm;
  assign rf_we_o   = dec_q.rf_we;
  assign opb_imm_o = dec_q.opb_imm;
  assign mem_rd_o  = dec_q.mem_rd;
  assign mem_wr_o  = dec_q.mem_wr;
  assign br_kind_o = dec_q.br;
  assign link_o    = dec_q.link;
  assign illegal_o = dec_q.illegal;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [15:0] insn_i,
  input logic        vld_o,
  input logic [3:0]  rd_o,
  input logic [15:0] imm_o,
  input logic        rf_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic [2:0]  br_kind_o,
  input logic        link_o,
  input logic        illegal_o
);
  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);

  p_bubble_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!vld_o && !rf_we_o && !mem_rd_o && !mem_wr_o && br_kind_o == 3'd0 && !illegal_o));

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!rf_we_o && !mem_rd_o && !mem_wr_o && br_kind_o == 3'd0 && !link_o));

  p_mem_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_link_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> (rf_we_o && rd_o == 4'd14 && (br_kind_o == 3'd3 || br_kind_o == 3'd4)));

  p_cc_dest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[3:2] == 2'b01) |=> (rd_o[3:2] == 2'b00 && rf_we_o));

  p_imm_sext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(imm_o[15:11]) == 0 || $countones(imm_o[15:11]) == 5));
endmodule

bind insn_decoder insn_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
  .vld_o(vld_o), .rd_o(rd_o), .imm_o(imm_o), .rf_we_o(rf_we_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .br_kind_o(br_kind_o),
  .link_o(link_o), .illegal_o(illegal_o)
);

// File: tb/insn_decoder_bench.sv
module insn_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [15:0] insn = '0;
  logic vld, rf_we, opb_imm, mem_rd, mem_wr, link, illegal;
  logic [3:0] ra, rb, rd, fn;
  logic [15:0] imm;
  logic [2:0] brk;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  insn_decoder u_insn_decoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .vld_o(vld), .ra_o(ra), .rb_o(rb), .rd_o(rd), .fn_o(fn), .imm_o(imm),
    .rf_we_o(rf_we), .opb_imm_o(opb_imm), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .br_kind_o(brk), .link_o(link), .illegal_o(illegal)
  );

  // expected values, grouped {vld,ra,rb,rd,fn} / imm / {we,opb,rd,wr,br,link,ill}
  logic [16:0] e_f;
  logic [15:0] e_i;
  logic [8:0]  e_c;
  string tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s insn=%h act=%h exp=%h", req, insn, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] w);
    int op = int'(w[3:0]);
    int sub = int'(w[15:12]);
    logic [3:0] a = w[7:4], b = w[11:8], h = w[15:12];
    logic [3:0] x_ra = 0, x_rb = 0, x_rd = 0, x_fn = 0;
    logic [2:0] x_br = 0;
    logic we = 0, ob = 0, mr = 0, mw = 0, lk = 0, il = 0;
    int v = 0;
    if (op <= 1) begin
      tag = "R3"; x_ra = a; x_rd = a; x_fn = (op == 1) ? 4'd7 : 4'd0;
      v = int'($signed(w[15:8])); ob = 1; we = 1;
    end else if (op == 2) begin
      tag = "R4"; x_ra = a; x_rb = b; x_rd = a; x_fn = h; we = 1;
    end else if (op == 3) begin
      tag = "R4"; x_ra = a; x_rd = a; x_fn = b; v = int'($signed(h)); ob = 1; we = 1;
    end else if (op <= 7) begin
      tag = "R5"; x_ra = a; x_rb = b; x_rd = 4'(op - 4); x_fn = h; we = 1;
    end else if (op <= 9) begin
      tag = "R6"; x_ra = a; x_rb = b; x_fn = 4'd4; v = int'($signed(h)); ob = 1;
      if (op == 8) begin mr = 1; we = 1; x_rd = a; end else mw = 1;
    end else if (op <= 11) begin
      tag = "R7"; x_ra = a; v = int'($signed(w[15:8])); x_br = (op == 10) ? 3'd1 : 3'd2;
    end else if (op <= 13) begin
      tag = "R8"; v = int'($signed(w[15:4])); x_br = 3'd3;
      if (op == 13) begin lk = 1; we = 1; x_rd = 4'd14; end
    end else if (op == 14 && sub <= 1) begin
      tag = "R9"; x_rb = b; x_br = 3'd4;
      if (sub == 1) begin lk = 1; we = 1; x_rd = 4'd14; end
    end else if (op == 14 && sub == 2) begin
      tag = "R9";
    end else begin
      tag = "R10"; il = 1;
    end
    e_f = {1'b1, x_ra, x_rb, x_rd, x_fn};
    e_i = 16'(v);
    e_c = {we, ob, mr, mw, x_br, lk, il};
  endtask

  task automatic compare(input string ft);
    logic [16:0] af = {vld, ra, rb, rd, fn};
    logic [8:0]  ac = {rf_we, opb_imm, mem_rd, mem_wr, brk, link, illegal};
    chk(af == e_f, {ft, " fields R2"}, 32'(af), 32'(e_f));
    chk(imm == e_i, {ft, " imm"}, 32'(imm), 32'(e_i));
    chk(ac == e_c, {ft, " ctrl"}, 32'(ac), 32'(e_c));
  endtask

  task automatic chk_zero(input string why);
    logic [47:0] all = {vld, ra, rb, rd, fn, imm, rf_we, opb_imm, mem_rd, mem_wr, brk, link, illegal};
    chk(all == '0, {"R1 ", why}, 32'(all), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_zero("reset");
    rst_n = 1'b1;
    // a word offered with valid low must not appear (R1)
    insn = 16'h1234; valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_zero("idle");
    // exhaustive sweep, a bubble after every 256th word
    for (int w = 0; w < 65536; w++) begin
      insn = 16'(w); valid = 1'b1;
      model(16'(w));
      @(posedge clk); @(negedge clk);
      compare(tag);
      if ((w & 255) == 255) begin
        valid = 1'b0; insn = ~16'(w);
        @(posedge clk); @(negedge clk);
        chk_zero("bubble");
      end
    end
    // boundary offsets, back to back (R7, R8, R4)
    for (int k = 0; k < 6; k++) begin
      logic [15:0] w;
      case (k)
        0: w = 16'h7F0A; 1: w = 16'h800B; 2: w = 16'h7FFC;
        3: w = 16'h800D; 4: w = 16'h7513; default: w = 16'h8A23;
      endcase
      insn = w; valid = 1'b1; model(w);
      @(posedge clk); @(negedge clk);
      compare({tag, " boundary"});
    end
    valid = 1'b0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule